// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block is a parallel I/O controller that hangs on a simple processor bus. It offers three 8-bit ports (A, B and C) and one write-only control register. Two address bits pick the target: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. The access is qualified by an active-low chip select and active-low read and write strobes. Every port line has its own output value and its own output-enable. A board-level pad ring turns these into tristate pins.

Software writes the control register in one of two ways. A mode-set word fixes the direction of port A, port B and each half of port C. It can also put port A into a strobed bidirectional mode. A bit set/reset word changes a single port C line. In the bidirectional mode, five upper port C lines become handshake and interrupt lines for port A:

- A CPU write fills the output buffer.
- The peripheral's acknowledge drives the data out and empties the buffer.
- The peripheral's strobe captures inbound data into a latch.
- A CPU read empties that latch.
- An interrupt line combines the two sides.

The bus has no back-pressure. Each access completes in the single clock cycle in which it is presented, and there is no stall or wait response. Read data is combinational from the address. The side effects of a read or write happen at the clock edge that ends that cycle.

Top module: `ppi_top`

## Requirements
- R1: After reset, every output-enable of ports A, B and C is 0, all output latches hold 00h, and the block behaves as if mode word 9Bh (every port a simple input) had been written.
- R2: A write takes effect on a clock edge where `cs_n`, `wr_n` are low. A read is a cycle where `cs_n`, `rd_n` are low and `wr_n` is high. `dout` carries the read data in that cycle and is 00h otherwise. Address 3 reads as 00h.
- R3: A control write with bit 7 set is a mode-set word. Its fields are:
  - bit 6: port A bidirectional mode.
  - bit 4: port A is an input.
  - bit 3: PC7..PC4 are inputs.
  - bit 1: port B is an input.
  - bit 0: PC3..PC0 are inputs.
  - For example, 98h makes A an input, B an output, lower C an output and upper C an input.
- R4: The one-direction strobed encodings are accepted and run as simple I/O with the decoded directions. These are bits 6:5 = 01 for group A and bit 2 set for group B. For example, AEh gives A as output, B as input, lower C as output and upper C as input.
- R5: In simple I/O, reading a port configured as input returns its pins, and reading one configured as output returns its latch. Port C is resolved per nibble, and each line's output-enable equals its output direction.
- R6: A mode-set word clears all three output latches, both buffer flags and both interrupt enables.
- R7: A control write with bit 7 clear sets port C latch bit `din[3:1]` to `din[0]` and leaves the port configuration unchanged. For example, 01h drives PC0 high and 00h drives it low.
- R8: In bidirectional mode, port C line directions are fixed for the upper lines and follow mode bit 0 for the lower ones. `pc_oe` is 1 on PC7, PC5 and PC3, 0 on PC6 and PC4, and `~bit0` on PC2..PC0. Port B still follows bit 1.
- R9: In bidirectional mode, a port A write sets the output-buffer-full flag, which drives PC7 low. A falling PC6 (acknowledge, active low) clears the flag. `pa_oe` is FFh only while PC6 is low and 00h while it is high.
- R10: In bidirectional mode, a falling PC4 (strobe, active low) captures `pa_in` and sets the input-buffer-full flag on PC5. A port A read returns the captured byte and clears the flag. A capture in the same cycle as the read wins.
- R11: PC3 = (INTE1 and PC6 high and buffer empty) or (INTE2 and PC4 high and input flag set). In bidirectional mode, bit set/reset on bit 6 writes INTE1 and on bit 4 writes INTE2.
- R12: In bidirectional mode, a port C read returns the following:
  - bit 7: the PC7 level.
  - bit 6: INTE1.
  - bit 5: the input-buffer-full flag.
  - bit 4: INTE2.
  - bit 3: PC3.
  - bits 2:0: the lower port C lines, resolved as in R5.
- R13: PC6 and PC4 pass through `SYNC_STAGES` synchronizer flops. A falling input seen first at clock edge k changes its flag at edge k+`SYNC_STAGES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output-enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output-enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C output-enables |

## Verification
The bench builds `ppi_top` with the default `SYNC_STAGES` of 2. This keeps the acknowledge and strobe latency short enough for the bench to check its exact edge: no change two falling clock edges after the pin drops, and a change on the third. With that depth, each handshake step of the bidirectional mode fits within a few cycles. The directed sequence can therefore walk the output-buffer, input-latch, interrupt-enable and status-word paths back to back, after a table of five mode words has covered every port-direction combination.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PW = 8;
  localparam int SELW = $clog2(PW);

  // Port C line roles in bidirectional mode
  localparam int PIN_OBF  = 7;
  localparam int PIN_ACK  = 6;
  localparam int PIN_IBF  = 5;
  localparam int PIN_STB  = 4;
  localparam int PIN_INTR = 3;
  localparam int LOW_TOP  = 2;
  localparam int HALF     = PW / 2;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  typedef struct packed {
    logic bidir;
    logic a_in;
    logic cu_in;
    logic b_in;
    logic cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{bidir: 1'b0, a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ppi_cfg.sv
module ppi_cfg
  import ppi_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_ctl,
  input  logic [PW-1:0]   din,
  output cfg_t            cfg,
  output logic            mode_wr,
  output logic            bsr_wr,
  output logic [SELW-1:0] bsr_sel,
  output logic            bsr_val
);
  assign mode_wr = wr_ctl & din[PW-1];
  assign bsr_wr  = wr_ctl & ~din[PW-1];
  assign bsr_sel = din[SELW:1];
  assign bsr_val = din[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (mode_wr) begin
      cfg.bidir <= din[6];
      cfg.a_in  <= din[4];
      cfg.cu_in <= din[3];
      cfg.b_in  <= din[1];
      cfg.cl_in <= din[0];
    end
  end

  // One-direction strobed group A encoding behaves as simple I/O
  AST_STROBED_AS_SIMPLE: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && din[6:5] == 2'b01) |=> (!cfg.bidir && cfg.a_in == $past(din[4]))); // R4
endmodule

// File: rtl/ppi_hsk.sv
module ppi_hsk
  import ppi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bidir,
  input  logic            mode_wr,
  input  logic            wr_pa,
  input  logic            rd_pa,
  input  logic            bsr_wr,
  input  logic [SELW-1:0] bsr_sel,
  input  logic            bsr_val,
  input  logic            ack_n_pin,
  input  logic            stb_n_pin,
  input  logic [PW-1:0]   pa_pins,
  output logic            obf,
  output logic            ibf,
  output logic            inte1,
  output logic            inte2,
  output logic            intr,
  output logic [PW-1:0]   in_latch
);
  logic ack_s, stb_s, ack_d, stb_d, ack_fall, stb_fall;

  ppi_sync #(.STAGES(SYNC_STAGES)) u_ack (.clk(clk), .rst(rst), .d(ack_n_pin), .q(ack_s));
  ppi_sync #(.STAGES(SYNC_STAGES)) u_stb (.clk(clk), .rst(rst), .d(stb_n_pin), .q(stb_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_d <= 1'b1;
      stb_d <= 1'b1;
    end else begin
      ack_d <= ack_s;
      stb_d <= stb_s;
    end
  end

  assign ack_fall = bidir & ack_d & ~ack_s;
  assign stb_fall = bidir & stb_d & ~stb_s;

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      obf   <= 1'b0;
      ibf   <= 1'b0;
      inte1 <= 1'b0;
      inte2 <= 1'b0;
    end else begin
      if (bidir && wr_pa)  obf <= 1'b1;
      else if (ack_fall)   obf <= 1'b0;
      if (stb_fall)             ibf <= 1'b1;
      else if (bidir && rd_pa)  ibf <= 1'b0;
      if (bidir && bsr_wr && bsr_sel == SELW'(PIN_ACK)) inte1 <= bsr_val;
      if (bidir && bsr_wr && bsr_sel == SELW'(PIN_STB)) inte2 <= bsr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           in_latch <= '0;
    else if (stb_fall) in_latch <= pa_pins;
  end

  assign intr = (inte1 & ack_s & ~obf) | (inte2 & stb_s & ibf);

  AST_OBF_SET: assert property (@(posedge clk) disable iff (rst)
    (bidir && wr_pa && !mode_wr) |=> obf); // R9
  AST_IBF_SET: assert property (@(posedge clk) disable iff (rst)
    (stb_fall && !mode_wr) |=> ibf); // R10
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (bidir && rd_pa && !stb_fall && !mode_wr) |=> !ibf); // R10
  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (!obf && !ibf && !inte1 && !inte2)); // R6
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] dout,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic [PW-1:0] pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic [PW-1:0] pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  logic wr, rd;
  cfg_t cfg;
  logic mode_wr, bsr_wr, bsr_val;
  logic [SELW-1:0] bsr_sel;
  logic [PW-1:0] lat_a, lat_b, lat_c, in_latch, rd_mux, c_simple;
  logic obf, ibf, inte1, inte2, intr;

  assign wr = ~cs_n & ~wr_n;
  assign rd = ~cs_n & ~rd_n & wr_n;

  ppi_cfg u_cfg (
    .clk(clk), .rst(rst), .wr_ctl(wr && addr == SEL_CTL), .din(din),
    .cfg(cfg), .mode_wr(mode_wr), .bsr_wr(bsr_wr), .bsr_sel(bsr_sel), .bsr_val(bsr_val)
  );

  ppi_hsk #(.SYNC_STAGES(SYNC_STAGES)) u_hsk (
    .clk(clk), .rst(rst), .bidir(cfg.bidir), .mode_wr(mode_wr),
    .wr_pa(wr && addr == SEL_A), .rd_pa(rd && addr == SEL_A),
    .bsr_wr(bsr_wr), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
    .ack_n_pin(pc_in[PIN_ACK]), .stb_n_pin(pc_in[PIN_STB]), .pa_pins(pa_in),
    .obf(obf), .ibf(ibf), .inte1(inte1), .inte2(inte2), .intr(intr), .in_latch(in_latch)
  );

  // Output latches
  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else begin
      if (wr && addr == SEL_A) lat_a <= din;
      if (wr && addr == SEL_B) lat_b <= din;
      if (wr && addr == SEL_C) lat_c <= din;
      else if (bsr_wr)         lat_c[bsr_sel] <= bsr_val;
    end
  end

  assign pa_out = lat_a;
  assign pa_oe  = cfg.bidir ? {PW{~pc_in[PIN_ACK]}} : {PW{~cfg.a_in}};
  assign pb_out = lat_b;
  assign pb_oe  = {PW{~cfg.b_in}};

  // Port C per-line pin mux
  generate
    for (genvar i = 0; i < PW; i++) begin : g_pc
      logic line_in;
      assign line_in     = (i >= HALF) ? cfg.cu_in : cfg.cl_in;
      assign c_simple[i] = line_in ? pc_in[i] : lat_c[i];
      if (i == PIN_OBF) begin : g_obf
        assign pc_out[i] = cfg.bidir ? ~obf : lat_c[i];
        assign pc_oe[i]  = cfg.bidir | ~line_in;
      end else if (i == PIN_IBF) begin : g_ibf
        assign pc_out[i] = cfg.bidir ? ibf : lat_c[i];
        assign pc_oe[i]  = cfg.bidir | ~line_in;
      end else if (i == PIN_INTR) begin : g_intr
        assign pc_out[i] = cfg.bidir ? intr : lat_c[i];
        assign pc_oe[i]  = cfg.bidir | ~line_in;
      end else if (i == PIN_ACK || i == PIN_STB) begin : g_hin
        assign pc_out[i] = lat_c[i];
        assign pc_oe[i]  = ~cfg.bidir & ~line_in;
      end else begin : g_plain
        assign pc_out[i] = lat_c[i];
        assign pc_oe[i]  = ~line_in;
      end
    end
  endgenerate

  always_comb begin
    unique case (addr)
      SEL_A:   rd_mux = cfg.bidir ? in_latch : (cfg.a_in ? pa_in : lat_a);
      SEL_B:   rd_mux = cfg.b_in ? pb_in : lat_b;
      SEL_C:   rd_mux = cfg.bidir ? {~obf, inte1, ibf, inte2, intr, c_simple[LOW_TOP:0]}
                                  : c_simple;
      default: rd_mux = '0;
    endcase
  end

  assign dout = rd ? rd_mux : '0;

  AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0)); // R1
  AST_PA_HIZ_ACK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cfg.bidir && pc_in[PIN_ACK]) |-> (pa_oe == '0)); // R9
  AST_BSR_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    bsr_wr |=> (pa_oe == $past(pa_oe) || cfg.bidir) && pb_oe == $past(pb_oe)); // R7
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> dout == '0); // R2
endmodule

// File: tb/ppi_top_test.sv
module ppi_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int checks = 0;
  int errors = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  ppi_top uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in),
    .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // cw, pa, pb, pc, wdata, expA, expB, expC, oeA, oeB, oeC
  localparam logic [87:0] VEC [5] = '{
    88'h98_3C_77_A5_5A_3C_5A_AA_00_FF_0F,  // R3
    88'h9B_11_22_33_C3_11_22_33_00_00_00,  // R5
    88'h80_11_22_33_C3_C3_C3_C3_FF_FF_FF,  // R5
    88'hAE_0F_F0_96_69_69_F0_99_FF_00_0F,  // R4
    88'h89_00_00_5C_E7_E7_E7_5C_FF_FF_00   // R5
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #5 d = dout;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    pa_in = 8'h5E; pb_in = 8'h6D; pc_in = 8'hC7;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    // Reset state
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    bus_rd(2'd2, rv); check("R1 read C pins", rv, 8'hC7);
    bus_rd(2'd0, rv); check("R1 read A pins", rv, 8'h5E);
    bus_rd(2'd3, rv); check("R2 ctl reads zero", rv, 8'h00);
    check("R2 idle dout", dout, 8'h00);

    // Table of mode words
    for (int i = 0; i < 5; i++) begin
      logic [87:0] v;
      v = VEC[i];
      bus_wr(2'd0, 8'hFF);
      bus_wr(2'd3, v[87:80]);
      check("R6 latch cleared by mode word", pa_out, 8'h00);
      pa_in = v[79:72]; pb_in = v[71:64]; pc_in = v[63:56];
      bus_wr(2'd0, v[55:48]);
      bus_wr(2'd1, v[55:48]);
      bus_wr(2'd2, v[55:48]);
      bus_rd(2'd0, rv); check("R5 read A", rv, v[47:40]);
      bus_rd(2'd1, rv); check("R5 read B", rv, v[39:32]);
      bus_rd(2'd2, rv); check("R5 read C", rv, v[31:24]);
      check("R3 pa_oe", pa_oe, v[23:16]);
      check("R3 pb_oe", pb_oe, v[15:8]);
      check("R3 pc_oe", pc_oe, v[7:0]);
    end

    // Bit set/reset
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h01);
    check("R7 PC0 high", pc_out, 8'h01);
    bus_wr(2'd3, 8'h0F);
    check("R7 PC7 high", pc_out, 8'h81);
    bus_wr(2'd3, 8'h00);
    check("R7 PC0 low", pc_out, 8'h80);
    check("R7 mode kept A", pa_oe, 8'hFF);
    check("R7 mode kept C", pc_oe, 8'hFF);

    // Bidirectional mode
    pc_in = 8'h50; pa_in = 8'h00;
    bus_wr(2'd3, 8'hC0);
    check("R8 pc_oe", pc_oe, 8'hAF);
    check("R9 pa tristate idle", pa_oe, 8'h00);
    bus_rd(2'd2, rv); check("R12 status idle", rv, 8'h80);
    bus_wr(2'd0, 8'hA5);
    check("R9 OBF# low", {7'd0, pc_out[7]}, 8'h00);
    bus_rd(2'd2, rv); check("R12 status full", rv, 8'h00);
    bus_wr(2'd3, 8'h0D);
    cycles(4);
    check("R11 no int while full", {7'd0, pc_out[3]}, 8'h00);
    pc_in[6] = 1'b0;
    #1;
    check("R9 drivers on ack low", pa_oe, 8'hFF);
    check("R9 data out", pa_out, 8'hA5);
    cycles(5);
    check("R9 OBF# released", {7'd0, pc_out[7]}, 8'h01);
    pc_in[6] = 1'b1;
    #1;
    check("R9 drivers off ack high", pa_oe, 8'h00);
    cycles(5);
    check("R11 output int", {7'd0, pc_out[3]}, 8'h01);
    bus_wr(2'd3, 8'h0C);
    check("R11 INTE1 off", {7'd0, pc_out[3]}, 8'h00);
    bus_wr(2'd3, 8'h09);
    @(negedge clk);
    pa_in = 8'h3C; pc_in[4] = 1'b0;
    cycles(2);
    check("R13 not yet latched", {7'd0, pc_out[5]}, 8'h00);
    cycles(1);
    check("R13 latched on time", {7'd0, pc_out[5]}, 8'h01);
    check("R10 IBF high", {7'd0, pc_out[5]}, 8'h01);
    check("R11 no int while strobe low", {7'd0, pc_out[3]}, 8'h00);
    cycles(2);
    pa_in = 8'h00; pc_in[4] = 1'b1;
    cycles(5);
    check("R11 input int", {7'd0, pc_out[3]}, 8'h01);
    bus_rd(2'd2, rv); check("R12 status both", rv, 8'hB8);
    bus_rd(2'd0, rv); check("R10 read latched", rv, 8'h3C);
    check("R10 IBF cleared", {7'd0, pc_out[5]}, 8'h00);
    check("R11 int dropped", {7'd0, pc_out[3]}, 8'h00);
    bus_rd(2'd2, rv); check("R12 status after read", rv, 8'h90);
    bus_wr(2'd3, 8'hC0);
    bus_rd(2'd2, rv); check("R6 mode clears enables", rv, 8'h80);
    finish_up();
  end
endmodule